// File: doc/BRIEF.md
# GPS C/A Test Signal Generator

This block produces a synthetic, down-converted GPS C/A sample stream, one sample per enabled clock, so that a correlator can be driven with a known signal. Two fixed-point phase accumulators advance on every enabled sample. The carrier accumulator selects one of eight carrier phases. The code accumulator selects the current spreading chip, and an internal pair of 10-stage shift registers generates those chips. The carrier value, the chip and the current navigation data bit are multiplied together, and the product is clamped to a small signed range.

A code period lasts CODE_LEN chips and raises a one-cycle epoch strobe. After EPOCHS_PER_BIT epochs a data-bit boundary is reached. At that boundary a navigation strobe is raised and a new data bit is taken from `nav_bit_i`. A two-state sequencer tracks where the generator is inside a data bit. In **BIT_OPEN**, the current epoch is not the last one of the data bit. In **BIT_LAST**, the final epoch of the data bit is running. The sequencer has three transitions, and each one happens only on an epoch wrap:
- **OPEN_STAY**: stays in BIT_OPEN while epochs are still left before the last one.
- **OPEN_TO_LAST**: moves from BIT_OPEN to BIT_LAST when the next-to-last epoch ends.
- **LAST_TO_OPEN**: moves from BIT_LAST back to BIT_OPEN at the data-bit boundary. When EPOCHS_PER_BIT is 1, the sequencer instead stays in BIT_LAST, and that transition is named **LAST_STAY**.

Top module: `gsg_top`

## Requirements
- R1: While `rst_i` is high at a clock edge, the following values are loaded. `sample_o`, `epoch_o` and `nav_stb_o` become 0. Both phase accumulators become 0. Both code shift registers are loaded with all ones. The navigation data bit becomes 0, which stands for +1.
- R2: Each enabled sample adds CARR_STEP to a 31-bit carrier phase, modulo 2^31. The carrier index is phase bits 30..28. Indices 0 to 7 map to the carrier values +LO_MAG, +HI_MAG, +HI_MAG, +LO_MAG, -LO_MAG, -HI_MAG, -HI_MAG, -LO_MAG.
- R3: Each enabled sample adds CODE_STEP to the code phase. The chip index is the code phase shifted right by 22. When the index reaches CODE_LEN, the index bits are cleared and only the 22-bit fraction is kept. `epoch_o` is high for exactly the one cycle that follows that enabled edge.
- R4: Chip bits are the XOR of three values: stage 10 of register A (feedback from stages 3 and 10), and two stages of register B (feedback from stages 2, 3, 6, 8, 9 and 10). The two B stages are selected by `code_sel_i[7:4]` and `code_sel_i[3:0]`, numbered 1 to 10. A select value outside 1 to 10 contributes 0. Both registers shift once per chip-index increment and reload all ones at the code-period wrap.
- R5: On each enabled edge, `sample_o` is loaded with the product nav × chip × carrier value, computed from the state before that edge. The result is clamped to ±CLAMP_MAG. Bit value 1 means -1 and bit value 0 means +1, for both nav and chip.
- R6: Every EPOCHS_PER_BIT-th epoch wrap raises `nav_stb_o` in the same cycle as `epoch_o`. The navigation bit used from then on is `nav_bit_i` sampled at that edge, with 0 standing for +1 and 1 for -1.
- R7: On a clock edge with `en_i` low, no phase, register or counter advances. `sample_o` holds its value, and `epoch_o` and `nav_stb_o` are 0 in the following cycle.
- R8: The sequencer leaves reset in BIT_OPEN, or in BIT_LAST when EPOCHS_PER_BIT is 1. It changes state only on an epoch wrap, following OPEN_STAY, OPEN_TO_LAST and LAST_TO_OPEN (or LAST_STAY). `nav_stb_o` is raised only by a wrap taken in BIT_LAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Sample enable; one sample per high edge |
| code_sel_i | input | 8 | Two B-register stage numbers, [7:4] and [3:0], range 1..10 |
| nav_bit_i | input | 1 | Next navigation data bit (0 = +1, 1 = -1) |
| sample_o | output | SAMPLE_W | Signed clamped sample |
| epoch_o | output | 1 | One-cycle strobe per code period |
| nav_stb_o | output | 1 | One-cycle strobe per data-bit boundary |

## Verification
The bench builds the block with the following parameters:
- CODE_STEP = 3000000, which makes a code period about 1431 samples long.
- EPOCHS_PER_BIT = 4, so several data-bit boundaries and navigation sign flips fall inside a short run.
- HI_MAG = 4 with CLAMP_MAG = 3. The larger carrier value is therefore clamped while the smaller one is not, so both the clamp path and the unclamped path show up in the samples.

The carrier step keeps its default, and the code period keeps its full length of 1023 chips. As a result, the chip sequences, the wrap of the code phase and the reload of the shift registers are all exercised at full size.

// File: rtl/gsg_pkg.sv
package gsg_pkg;

    typedef enum logic [0:0] {
        BIT_OPEN = 1'b0,
        BIT_LAST = 1'b1
    } bit_state_e;

    localparam int LFSR_N = 10;
    localparam int SEL_W  = 4;

    // carrier half: indices 4..7 carry the negative sign
    function automatic logic carr_negative(input logic [2:0] idx);
        return idx[2];
    endfunction

    // indices 1,2,5,6 carry the larger magnitude
    function automatic logic carr_large(input logic [2:0] idx);
        return idx[1] ^ idx[0];
    endfunction

endpackage

// File: rtl/gsg_carrier.sv
module gsg_carrier #(
    parameter int          CARR_W    = 31,
    parameter int unsigned CARR_STEP = 528038944
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    output logic [2:0] phase_idx_o
);
    logic [CARR_W-1:0] phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
        end else if (en_i) begin
            phase_q <= phase_q + CARR_W'(CARR_STEP);
        end
    end

    assign phase_idx_o = phase_q[CARR_W-1 -: 3];
endmodule

// File: rtl/gsg_code.sv
module gsg_code
    import gsg_pkg::*;
#(
    parameter int          CODE_LEN  = 1023,
    parameter int          FRAC_W    = 22,
    parameter int unsigned CODE_STEP = 750923
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_a_i,
    input  logic [SEL_W-1:0] sel_b_i,
    output logic             chip_o,
    output logic             wrap_o
);
    localparam int IDX_W = $clog2(CODE_LEN + 1);
    localparam int ACC_W = IDX_W + FRAC_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_sum;
    logic [LFSR_N-1:0] ga_q, gb_q, ga_nx, gb_nx;
    logic              period_end, chip_step;
    logic [1:0]        tap_val;
    logic [SEL_W-1:0]  sel_pair [2];

    assign sel_pair[0] = sel_a_i;
    assign sel_pair[1] = sel_b_i;

    assign acc_sum    = acc_q + ACC_W'(CODE_STEP);
    assign period_end = (acc_sum[ACC_W-1:FRAC_W] == IDX_W'(CODE_LEN));
    assign chip_step  = (acc_sum[ACC_W-1:FRAC_W] != acc_q[ACC_W-1:FRAC_W]);

    // stage s lives at bit s-1; a shift moves stage s into stage s+1
    assign ga_nx = {ga_q[LFSR_N-2:0], ga_q[2] ^ ga_q[9]};
    assign gb_nx = {gb_q[LFSR_N-2:0],
                    gb_q[1] ^ gb_q[2] ^ gb_q[5] ^ gb_q[7] ^ gb_q[8] ^ gb_q[9]};

    for (genvar k = 0; k < 2; k++) begin : g_tap
        logic picked;
        always_comb begin
            picked = 1'b0;
            for (int s = 1; s <= LFSR_N; s++) begin
                if (int'(sel_pair[k]) == s) picked = gb_q[s-1];
            end
        end
        assign tap_val[k] = picked;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
            ga_q  <= '1;
            gb_q  <= '1;
        end else if (en_i) begin
            if (period_end) begin
                acc_q <= {{IDX_W{1'b0}}, acc_sum[FRAC_W-1:0]};
                ga_q  <= '1;
                gb_q  <= '1;
            end else begin
                acc_q <= acc_sum;
                if (chip_step) begin
                    ga_q <= ga_nx;
                    gb_q <= gb_nx;
                end
            end
        end
    end

    assign chip_o = ga_q[LFSR_N-1] ^ tap_val[0] ^ tap_val[1];
    assign wrap_o = en_i & period_end;
endmodule

// File: rtl/gsg_seq.sv
module gsg_seq
    import gsg_pkg::*;
#(
    parameter int EPOCHS_PER_BIT = 20
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic epoch_wrap_i,
    input  logic nav_bit_i,
    output logic nav_o,
    output logic bit_wrap_o,
    output logic last_o
);
    localparam int         EP_W     = (EPOCHS_PER_BIT > 1) ? $clog2(EPOCHS_PER_BIT) : 1;
    localparam bit_state_e ST_RESET = (EPOCHS_PER_BIT == 1) ? BIT_LAST : BIT_OPEN;

    bit_state_e      state_q, state_nx;
    logic [EP_W-1:0] count_q, count_nx;
    logic            nav_q;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        count_nx = count_q;
        unique case (state_q)
            BIT_OPEN: begin
                if (epoch_wrap_i) begin
                    count_nx = count_q + 1'b1;
                    if (int'(count_q) == EPOCHS_PER_BIT - 2) begin
                        state_nx = BIT_LAST;                   // OPEN_TO_LAST
                    end                                        // else OPEN_STAY
                end
            end
            BIT_LAST: begin
                if (epoch_wrap_i) begin
                    count_nx = '0;
                    state_nx = (EPOCHS_PER_BIT == 1) ? BIT_LAST // LAST_STAY
                                                     : BIT_OPEN; // LAST_TO_OPEN
                end
            end
            default: state_nx = ST_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_RESET;
            count_q <= '0;
        end else begin
            state_q <= state_nx;
            count_q <= count_nx;
        end
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            nav_q <= 1'b0;
        end else if (epoch_wrap_i && state_q == BIT_LAST) begin
            nav_q <= nav_bit_i;
        end
    end

    assign bit_wrap_o = epoch_wrap_i && (state_q == BIT_LAST);
    assign last_o     = (state_q == BIT_LAST);
    assign nav_o      = nav_q;
endmodule

// File: rtl/gsg_mix.sv
module gsg_mix
    import gsg_pkg::*;
#(
    parameter int SAMPLE_W  = 4,
    parameter int LO_MAG    = 1,
    parameter int HI_MAG    = 2,
    parameter int CLAMP_MAG = 6
) (
    input  logic                       nav_i,
    input  logic                       chip_i,
    input  logic [2:0]                 carr_idx_i,
    output logic signed [SAMPLE_W-1:0] sample_o
);
    int   mag;
    logic neg;

    always_comb begin
        mag = carr_large(carr_idx_i) ? HI_MAG : LO_MAG;
        if (mag > CLAMP_MAG) mag = CLAMP_MAG;
        neg = nav_i ^ chip_i ^ carr_negative(carr_idx_i);
        sample_o = neg ? SAMPLE_W'(-mag) : SAMPLE_W'(mag);
    end
endmodule

// File: rtl/gsg_top.sv
module gsg_top
    import gsg_pkg::*;
#(
    parameter int          CARR_STEP      = 528038944,
    parameter int          CODE_LEN       = 1023,
    parameter int unsigned CODE_STEP      = 750923,
    parameter int          EPOCHS_PER_BIT = 20,
    parameter int          SAMPLE_W       = 4,
    parameter int          LO_MAG         = 1,
    parameter int          HI_MAG         = 2,
    parameter int          CLAMP_MAG      = 6
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       en_i,
    input  logic [7:0]                 code_sel_i,
    input  logic                       nav_bit_i,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic                       epoch_o,
    output logic                       nav_stb_o
);
    logic [2:0]                 carr_idx;
    logic                       chip, code_wrap, bit_wrap, nav_cur, seq_last;
    logic signed [SAMPLE_W-1:0] mix_val;

    gsg_carrier #(.CARR_W(31), .CARR_STEP(CARR_STEP)) i_carrier (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .phase_idx_o(carr_idx)
    );

    gsg_code #(.CODE_LEN(CODE_LEN), .FRAC_W(22), .CODE_STEP(CODE_STEP)) i_code (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
        .sel_a_i(code_sel_i[7:4]), .sel_b_i(code_sel_i[3:0]),
        .chip_o(chip), .wrap_o(code_wrap)
    );

    gsg_seq #(.EPOCHS_PER_BIT(EPOCHS_PER_BIT)) i_seq (
        .clk_i(clk_i), .rst_i(rst_i), .epoch_wrap_i(code_wrap),
        .nav_bit_i(nav_bit_i), .nav_o(nav_cur), .bit_wrap_o(bit_wrap),
        .last_o(seq_last)
    );

    gsg_mix #(.SAMPLE_W(SAMPLE_W), .LO_MAG(LO_MAG), .HI_MAG(HI_MAG),
              .CLAMP_MAG(CLAMP_MAG)) i_mix (
        .nav_i(nav_cur), .chip_i(chip), .carr_idx_i(carr_idx), .sample_o(mix_val)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sample_o  <= '0;
            epoch_o   <= 1'b0;
            nav_stb_o <= 1'b0;
        end else begin
            epoch_o   <= code_wrap;
            nav_stb_o <= bit_wrap;
            if (en_i) sample_o <= mix_val;
        end
    end
endmodule

// File: rtl/gsg_chk.sv
module gsg_chk #(
    parameter int SAMPLE_W  = 4,
    parameter int CLAMP_MAG = 6
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic                       en_i,
    input logic signed [SAMPLE_W-1:0] sample_o,
    input logic                       epoch_o,
    input logic                       nav_stb_o,
    input logic                       seq_last
);
    // R5
    sample_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(sample_o) <= CLAMP_MAG) && (int'(sample_o) >= -CLAMP_MAG));

    // R5
    sample_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (sample_o != '0));

    // R6
    nav_with_epoch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        nav_stb_o |-> epoch_o);

    // R7
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!epoch_o && !nav_stb_o && $stable(sample_o)));

    // R3
    epoch_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        epoch_o |=> !epoch_o);

    // R8
    nav_from_last_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        nav_stb_o |-> $past(seq_last));
endmodule

bind gsg_top gsg_chk #(.SAMPLE_W(SAMPLE_W), .CLAMP_MAG(CLAMP_MAG)) i_chk (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .sample_o(sample_o),
    .epoch_o(epoch_o), .nav_stb_o(nav_stb_o), .seq_last(seq_last)
);

// File: tb/test_gsg_top.sv
module test_gsg_top;
    localparam int          P_CARR  = 528038944;
    localparam int          P_LEN   = 1023;
    localparam int unsigned P_CSTEP = 3000000;
    localparam int          P_EPB   = 4;
    localparam int          P_LO    = 1;
    localparam int          P_HI    = 4;
    localparam int          P_CLAMP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] code_sel = 8'h26;
    logic       nav_bit  = 1'b0;
    logic signed [3:0] sample;
    logic       epoch, nav_stb;

    always #2 clk = ~clk;

    gsg_top #(.CARR_STEP(P_CARR), .CODE_LEN(P_LEN), .CODE_STEP(P_CSTEP),
              .EPOCHS_PER_BIT(P_EPB), .SAMPLE_W(4), .LO_MAG(P_LO),
              .HI_MAG(P_HI), .CLAMP_MAG(P_CLAMP)) i_gsg_top (
        .clk_i(clk), .rst_i(rst), .en_i(en), .code_sel_i(code_sel),
        .nav_bit_i(nav_bit), .sample_o(sample), .epoch_o(epoch),
        .nav_stb_o(nav_stb)
    );

    int checks = 0, failures = 0;
    string tag = "R5";
    bit done = 1'b0;

    // spreading sequence tables, indexed by chip
    bit         a_bit [P_LEN];
    logic [9:0] b_st  [P_LEN];

    function automatic bit sel_bit(logic [9:0] st, logic [3:0] t);
        if (t >= 1 && t <= 10) return st[t-1];
        return 1'b0;
    endfunction

    initial begin
        logic [9:0] ra, rb;
        ra = '1; rb = '1;
        for (int i = 0; i < P_LEN; i++) begin
            a_bit[i] = ra[9];
            b_st[i]  = rb;
            ra = {ra[8:0], ra[2] ^ ra[9]};
            rb = {rb[8:0], rb[1] ^ rb[2] ^ rb[5] ^ rb[7] ^ rb[8] ^ rb[9]};
        end
    end

    // behavioural reference
    longint carr = 0, code = 0;
    int     ep = 0, navv = 0, exp_s = 0, en_edges = 0;
    bit     exp_e = 0, exp_n = 0;

    always @(posedge clk) begin
        if (rst) begin
            carr = 0; code = 0; ep = 0; navv = 0; exp_s = 0; exp_e = 0; exp_n = 0;
        end else begin
            exp_e = 0; exp_n = 0;
            if (en) begin
                int ci, idx, mag;
                bit ch, ng;
                en_edges++;
                ci  = int'((carr >> 28) & 7);
                idx = int'(code >> 22);
                ch  = a_bit[idx] ^ sel_bit(b_st[idx], code_sel[7:4]) ^ sel_bit(b_st[idx], code_sel[3:0]);
                mag = (ci == 1 || ci == 2 || ci == 5 || ci == 6) ? P_HI : P_LO;
                if (mag > P_CLAMP) mag = P_CLAMP;
                ng  = (navv != 0) ^ ch ^ (ci >= 4);
                exp_s = ng ? -mag : mag;
                carr = (carr + longint'(P_CARR)) & 64'h7FFF_FFFF;
                code = code + longint'(P_CSTEP);
                if ((code >> 22) == P_LEN) begin
                    code  = code & 64'h3F_FFFF;
                    exp_e = 1;
                    ep++;
                    if (ep == P_EPB) begin
                        ep = 0; exp_n = 1; navv = nav_bit;
                    end
                end
            end
        end
    end

    task automatic check(string req, int got, int expv, string what);
        checks++;
        if (got != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, got, expv, $time);
        end
    endtask

    int epoch_seen = 0, nav_seen = 0, first_epoch_at = -1;

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(tag, int'(sample), exp_s, "sample (R2 carrier, R4 chip, R5 product)");
            check("R3", int'(epoch), int'(exp_e), "epoch strobe");
            check("R6", int'(nav_stb), int'(exp_n), "nav strobe");
            if (epoch) begin
                epoch_seen++;
                if (first_epoch_at < 0) first_epoch_at = en_edges;
            end
            if (nav_stb) nav_seen++;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++; failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            en = (mode == 0) ? 1'b1 : ((i % 3) != 0);
        end
    endtask

    initial begin
        longint need;
        repeat (4) @(negedge clk);
        // R1 reset values
        check("R1", int'(sample), 0, "sample in reset");
        check("R1", int'(epoch), 0, "epoch in reset");
        check("R1", int'(nav_stb), 0, "nav strobe in reset");
        #1 rst = 1'b0;
        tag = "R2";
        nav_bit = 1'b1;
        run(3000, 0);
        // R3 first epoch after ceil(1023*2^22/step) enabled samples
        need = (longint'(P_LEN) * 64'd4194304 + longint'(P_CSTEP) - 1) / longint'(P_CSTEP);
        check("R3", first_epoch_at, int'(need), "samples to first epoch");
        tag = "R7";
        run(4000, 1);
        tag = "R4";
        code_sel = 8'h37;
        run(6000, 0);
        nav_bit = 1'b0;
        tag = "R6";
        run(6000, 0);
        tag = "R4";
        code_sel = 8'hF5;
        run(2500, 0);
        tag = "R5";
        code_sel = 8'h5A;
        run(2000, 0);
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        // R8 one data-bit boundary per EPOCHS_PER_BIT epochs
        check("R8", nav_seen, epoch_seen / P_EPB, "nav strobes vs epochs");
        check("R8", int'(nav_seen > 1), 1, "several bit boundaries");
        check("R3", int'(epoch_seen > 8), 1, "several epochs");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule